// File: doc/BRIEF.md
# Hub Downstream Port Resume Sequencer

This block handles selective suspend and wake-up for the downstream ports of a USB hub. Software parks any port in selective suspend by writing a control register. While a port is parked and the hub itself is awake, the block watches the port's decoded line state. When a K state appears, the block takes over the port at once. It disables the port, drives K on it, records the event in a read-only status register and raises the hub interrupt.

Software answers the interrupt by clearing the port's suspend flag. That also clears the status flag, but the K keeps going until a full resume period has passed since detection. The block then ends the resume with a line sequence that software cannot disturb. On the next low-speed bit boundary it drives SE0 for a fixed number of bit times, then J for one bit time, then idle for one clock. After that it enables the port again. A strict SE0 length matters because a longer SE0 looks like a bus reset to the device downstream.

Inputs are a 1 ms tick, a low-speed bit-time tick, a hub-suspended flag, one K-detect line per port and a simple register write/read port. The transceivers and the repeater data path live elsewhere.

Top module: `hub_port_resume`

## Requirements
- R1: After reset, both registers read 0x00, every port is enabled, no drive request is active and the interrupt is low.
- R2: The control register is at address 0. Bits 3..0 are the suspend flags for ports 0..3 (1 = suspended) and bit 7 is a readable and writable remote-wakeup flag. Bits 6..4 read 0, and writing them has no effect.
- R3: The status register is at address 1. Bits 3..0 are the per-port resume flags and bits 7..4 read 0. Writes to address 1 have no effect.
- R4: A port is suspended, the hub is not suspended and the port's K-detect input is 1 at a clock edge. In the next cycle the port drives K, its status bit reads 1, its enable is 0 and the interrupt is 1.
- R5: A K on a port whose suspend flag is 0, or any K while the hub-suspended input is 1, starts no sequence and sets no status bit.
- R6: Writing 0 to a set suspend flag clears that port's status bit in the cycle after the write.
- R7: K lasts at least K_MS periods of the 1 ms tick from detection. It also continues for as long as the suspend flag stays set.
- R8: K is followed by SE0 for exactly SE0_BITS bit-tick periods, then J for exactly one bit-tick period, then idle for one clock. Only one drive request is active at a time.
- R9: Register writes and line activity during SE0 neither lengthen nor shorten it.
- R10: The port enable stays 0 from detection through the idle cycle and returns to 1 in the next cycle.
- R11: The interrupt is high exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| bit_tick | input | 1 | One-cycle pulse every low-speed bit time |
| hub_suspended | input | 1 | Hub itself is suspended; blocks detection |
| line_k | input | NPORTS | Per-port decoded K line state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, combinational |
| drv_k | output | NPORTS | Request to drive K |
| drv_se0 | output | NPORTS | Request to drive SE0 |
| drv_j | output | NPORTS | Request to drive J |
| drv_idle | output | NPORTS | Request to drive idle |
| port_en | output | NPORTS | Port enabled for repeated traffic |
| hub_irq | output | 1 | Hub interrupt |

## Verification
Detection, status set, interrupt and disable all appear one cycle after the edge that samples the K input. Register writes show up in read data one cycle after the write strobe. The bench drives on falling edges and samples one falling edge after each stimulus. A monitor measures every drive segment in clock cycles and compares it against a queue of expected segments pushed by the stimulus tasks. SE0 and J must match 2 and 1 bit-tick periods exactly, and K must reach its minimum length, whatever the phase of the ticks.

// File: rtl/hub_rs_pkg.sv
package hub_rs_pkg;

    typedef enum logic [2:0] {
        PS_RUN,
        PS_SLEEP,
        PS_KHW,
        PS_KEXT,
        PS_SE0,
        PS_JBIT,
        PS_IDLE
    } port_state_e;

    localparam logic ADDR_CTRL   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

endpackage

// File: rtl/hub_rs_regs.sv
module hub_rs_regs
    import hub_rs_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    input  logic [NPORTS-1:0] hit,
    output logic [DW-1:0]     rdata,
    output logic [NPORTS-1:0] susp_q_o,
    output logic [NPORTS-1:0] susp_d_o,
    output logic [NPORTS-1:0] status_q_o
);

    localparam int WAKE_BIT = DW - 1;

    typedef struct packed {
        logic [NPORTS-1:0] susp;
        logic [NPORTS-1:0] status;
        logic              wake;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we && addr == ADDR_CTRL) begin
            r_d.susp = wdata[NPORTS-1:0];
            r_d.wake = wdata[WAKE_BIT];
        end
        // status sets on a detection and clears only on a suspend flag falling
        r_d.status = (r_q.status | hit) & ~(r_q.susp & ~r_d.susp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[NPORTS-1:0] = r_q.susp;
            rdata[WAKE_BIT]   = r_q.wake;
        end else begin
            rdata[NPORTS-1:0] = r_q.status;
        end
    end

    assign susp_q_o   = r_q.susp;
    assign susp_d_o   = r_d.susp;
    assign status_q_o = r_q.status;

endmodule

// File: rtl/hub_rs_port.sv
module hub_rs_port
    import hub_rs_pkg::*;
#(
    parameter int K_MS     = 10,
    parameter int SE0_BITS = 2,
    parameter int J_BITS   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic bit_tick,
    input  logic hub_suspended,
    input  logic line_k,
    input  logic susp_nx,
    output logic resume_hit,
    output logic drv_k,
    output logic drv_se0,
    output logic drv_j,
    output logic drv_idle,
    output logic port_en
);

    // one extra tick guarantees K_MS full periods whatever the tick phase
    localparam int K_TICKS = K_MS + 1;
    localparam int KW      = $clog2(K_TICKS + 1);
    localparam int BMAX    = (SE0_BITS > J_BITS) ? SE0_BITS : J_BITS;
    localparam int BW      = $clog2(BMAX + 1);

    typedef struct packed {
        port_state_e    state;
        logic [KW-1:0]  kcnt;
        logic [BW-1:0]  bcnt;
    } pst_t;

    pst_t s_d, s_q;
    logic kdone;

    assign kdone = (s_q.kcnt == KW'(K_TICKS));

    always_comb begin
        s_d        = s_q;
        resume_hit = 1'b0;
        if ((s_q.state == PS_KHW || s_q.state == PS_KEXT) && ms_tick && !kdone) begin
            s_d.kcnt = s_q.kcnt + 1'b1;
        end
        case (s_q.state)
            PS_RUN: begin
                if (susp_nx) s_d.state = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (!susp_nx) begin
                    s_d.state = PS_RUN;
                end else if (line_k && !hub_suspended) begin
                    s_d.state  = PS_KHW;
                    s_d.kcnt   = '0;
                    resume_hit = 1'b1;
                end
            end
            PS_KHW: begin
                if (!susp_nx) s_d.state = PS_KEXT;
            end
            PS_KEXT: begin
                if (kdone && bit_tick) begin
                    s_d.state = PS_SE0;
                    s_d.bcnt  = '0;
                end
            end
            PS_SE0: begin
                if (bit_tick) begin
                    if (s_q.bcnt == BW'(SE0_BITS - 1)) begin
                        s_d.state = PS_JBIT;
                        s_d.bcnt  = '0;
                    end else begin
                        s_d.bcnt = s_q.bcnt + 1'b1;
                    end
                end
            end
            PS_JBIT: begin
                if (bit_tick) begin
                    if (s_q.bcnt == BW'(J_BITS - 1)) begin
                        s_d.state = PS_IDLE;
                        s_d.bcnt  = '0;
                    end else begin
                        s_d.bcnt = s_q.bcnt + 1'b1;
                    end
                end
            end
            PS_IDLE: s_d.state = PS_RUN;
            default: s_d.state = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: PS_RUN, kcnt: '0, bcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign drv_k    = (s_q.state == PS_KHW) || (s_q.state == PS_KEXT);
    assign drv_se0  = (s_q.state == PS_SE0);
    assign drv_j    = (s_q.state == PS_JBIT);
    assign drv_idle = (s_q.state == PS_IDLE);
    assign port_en  = (s_q.state == PS_RUN) || (s_q.state == PS_SLEEP);

endmodule

// File: rtl/hub_port_resume.sv
module hub_port_resume
    import hub_rs_pkg::*;
#(
    parameter int NPORTS   = 4,
    parameter int DW       = 8,
    parameter int K_MS     = 10,
    parameter int SE0_BITS = 2,
    parameter int J_BITS   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              bit_tick,
    input  logic              hub_suspended,
    input  logic [NPORTS-1:0] line_k,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NPORTS-1:0] drv_k,
    output logic [NPORTS-1:0] drv_se0,
    output logic [NPORTS-1:0] drv_j,
    output logic [NPORTS-1:0] drv_idle,
    output logic [NPORTS-1:0] port_en,
    output logic              hub_irq
);

    logic [NPORTS-1:0] hit;
    logic [NPORTS-1:0] susp_q;
    logic [NPORTS-1:0] susp_d;
    logic [NPORTS-1:0] status_q;

    hub_rs_regs #(.NPORTS(NPORTS), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .hit        (hit),
        .rdata      (reg_rdata),
        .susp_q_o   (susp_q),
        .susp_d_o   (susp_d),
        .status_q_o (status_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        hub_rs_port #(.K_MS(K_MS), .SE0_BITS(SE0_BITS), .J_BITS(J_BITS)) u_port (
            .clk           (clk),
            .rst_n         (rst_n),
            .ms_tick       (ms_tick),
            .bit_tick      (bit_tick),
            .hub_suspended (hub_suspended),
            .line_k        (line_k[p]),
            .susp_nx       (susp_d[p]),
            .resume_hit    (hit[p]),
            .drv_k         (drv_k[p]),
            .drv_se0       (drv_se0[p]),
            .drv_j         (drv_j[p]),
            .drv_idle      (drv_idle[p]),
            .port_en       (port_en[p])
        );
    end

    assign hub_irq = |status_q;

endmodule

// File: rtl/hub_port_resume_chk.sv
module hub_port_resume_chk #(
    parameter int NPORTS   = 4,
    parameter int K_MS     = 10,
    parameter int SE0_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ms_tick,
    input logic              bit_tick,
    input logic [NPORTS-1:0] drv_k,
    input logic [NPORTS-1:0] drv_se0,
    input logic [NPORTS-1:0] drv_j,
    input logic [NPORTS-1:0] drv_idle,
    input logic [NPORTS-1:0] port_en,
    input logic              hub_irq
);

    localparam int KTW = $clog2(K_MS + 2);
    localparam int STW = $clog2(SE0_BITS + 2);

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        logic [KTW-1:0] kt_q;
        logic [STW-1:0] st_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                kt_q <= '0;
                st_q <= '0;
            end else begin
                if (!drv_k[p]) kt_q <= '0;
                else if (ms_tick && kt_q != KTW'(K_MS + 1)) kt_q <= kt_q + 1'b1;
                if (!drv_se0[p]) st_q <= '0;
                else if (bit_tick && st_q != STW'(SE0_BITS + 1)) st_q <= st_q + 1'b1;
            end
        end

        AST_K_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(drv_k[p]) |-> (kt_q >= KTW'(K_MS))); // R7
        AST_SE0_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
            st_q <= STW'(SE0_BITS)); // R9
        AST_SE0_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(drv_se0[p]) |-> (st_q == STW'(SE0_BITS))); // R8
        AST_SE0_AFTER_K: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_se0[p]) |-> $past(drv_k[p])); // R8
        AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({drv_k[p], drv_se0[p], drv_j[p], drv_idle[p]})); // R8
        AST_DRIVE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_k[p] || drv_se0[p] || drv_j[p] || drv_idle[p]) |-> !port_en[p]); // R10
        AST_IDLE_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            drv_idle[p] |=> port_en[p]); // R10
        AST_K_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_k[p]) |-> hub_irq); // R4
    end

endmodule

bind hub_port_resume hub_port_resume_chk #(
    .NPORTS(NPORTS), .K_MS(K_MS), .SE0_BITS(SE0_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bit_tick(bit_tick),
    .drv_k(drv_k), .drv_se0(drv_se0), .drv_j(drv_j), .drv_idle(drv_idle),
    .port_en(port_en), .hub_irq(hub_irq)
);

// File: tb/hub_port_resume_test.sv
`timescale 1ns/1ps
module hub_port_resume_test;

    localparam int NP    = 4;
    localparam int MS_P  = 40;
    localparam int BT_P  = 6;
    localparam int K_MS  = 10;
    localparam int C_K = 1, C_SE0 = 2, C_J = 3, C_IDLE = 4;

    logic clk = 0, rst_n = 0, ms_tick = 0, bit_tick = 0, hub_suspended = 0;
    logic [NP-1:0] line_k = '0;
    logic reg_we = 0, reg_addr = 0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [NP-1:0] drv_k, drv_se0, drv_j, drv_idle, port_en;
    logic hub_irq;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { int port; int code; int len; bit exact; string req; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    hub_port_resume uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bit_tick(bit_tick),
        .hub_suspended(hub_suspended), .line_k(line_k), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .drv_k(drv_k), .drv_se0(drv_se0), .drv_j(drv_j), .drv_idle(drv_idle),
        .port_en(port_en), .hub_irq(hub_irq)
    );

    initial begin
        int msc = 0, btc = 0;
        forever begin
            @(negedge clk);
            msc = (msc + 1) % MS_P;
            btc = (btc + 1) % BT_P;
            ms_tick  = (msc == 0);
            bit_tick = (btc == 0);
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(string req, logic a, int exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic push_resume(int p);
        sb.push_back('{p, C_K, K_MS * MS_P, 1'b0, "R7"});
        sb.push_back('{p, C_SE0, 2 * BT_P, 1'b1, "R9"});
        sb.push_back('{p, C_J, BT_P, 1'b1, "R8"});
        sb.push_back('{p, C_IDLE, 1, 1'b1, "R8"});
    endtask

    // monitor: measures drive segments and compares against the scoreboard
    int cur_code [NP];
    int cur_len  [NP];
    bit en_bad   [NP];
    initial begin
        for (int p = 0; p < NP; p++) begin cur_code[p] = 0; cur_len[p] = 0; en_bad[p] = 0; end
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int p = 0; p < NP; p++) begin
                    int code;
                    code = drv_k[p] ? C_K : drv_se0[p] ? C_SE0 : drv_j[p] ? C_J :
                           drv_idle[p] ? C_IDLE : 0;
                    if (code == cur_code[p]) begin
                        cur_len[p]++;
                    end else begin
                        if (cur_code[p] != 0) begin
                            checks++;
                            if (sb.size() == 0) begin
                                errors++;
                                $display("FAIL R5: port %0d unexpected code %0d actual len %0d expected none",
                                         p, cur_code[p], cur_len[p]);
                            end else begin
                                exp_t e;
                                e = sb.pop_front();
                                if (e.port != p || e.code != cur_code[p] ||
                                    (e.exact ? cur_len[p] != e.len : cur_len[p] < e.len)) begin
                                    errors++;
                                    $display("FAIL %s: port %0d code %0d len %0d, expected port %0d code %0d len %0d",
                                             e.req, p, cur_code[p], cur_len[p], e.port, e.code, e.len);
                                end
                            end
                            checks++;
                            if (en_bad[p]) begin
                                errors++;
                                $display("FAIL R10: port %0d enabled during code %0d actual 1 expected 0",
                                         p, cur_code[p]);
                            end
                            en_bad[p] = 0;
                        end
                        cur_code[p] = code;
                        cur_len[p]  = 1;
                    end
                    if (code != 0 && port_en[p]) en_bad[p] = 1;
                end
            end
        end
    end

    task automatic wait_enabled(int p);
        for (int i = 0; i < 5000 && !port_en[p]; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd("R1", 0, 0);
        rd("R1", 1, 0);
        check("R1", port_en, 4'hF);
        check("R1", {drv_k, drv_se0, drv_j, drv_idle}, 0);
        check("R1", hub_irq, 0);

        // R2 control register layout, reserved bits
        wr(0, 8'hFF);
        rd("R2", 0, 8'h8F);
        wr(0, 8'h00);
        rd("R2", 0, 8'h00);

        // R5 K on a port not suspended
        line_k[2] = 1;
        repeat (5) @(negedge clk);
        check("R5", drv_k, 0);
        check("R5", port_en, 4'hF);
        rd("R5", 1, 0);
        line_k[2] = 0;

        // R4 detection on port 1
        wr(0, 8'h02);
        repeat (2) @(negedge clk);
        push_resume(1);
        line_k[1] = 1;
        @(negedge clk);
        line_k[1] = 0;
        check("R4", drv_k[1], 1);
        check("R4", port_en[1], 0);
        check("R4", hub_irq, 1);
        rd("R4", 1, 8'h02);
        // R3 status is read-only
        wr(1, 8'h00);
        rd("R3", 1, 8'h02);
        wr(1, 8'hFF);
        rd("R3", 1, 8'h02);
        repeat (20) @(negedge clk);
        check("R7", drv_k[1], 1);
        // R6 clearing the suspend flag clears status, K continues
        wr(0, 8'h00);
        rd("R6", 1, 8'h00);
        check("R11", hub_irq, 0);
        check("R7", drv_k[1], 1);
        wait_enabled(1);
        check("R10", port_en, 4'hF);

        // R7/R9 late clear on port 3, disturbance during SE0
        wr(0, 8'h08);
        repeat (2) @(negedge clk);
        push_resume(3);
        line_k[3] = 1;
        @(negedge clk);
        line_k[3] = 0;
        repeat (500) @(negedge clk);
        check("R7", drv_k[3], 1);
        wr(0, 8'h00);
        for (int i = 0; i < 1000 && !drv_se0[3]; i++) @(negedge clk);
        check("R9", drv_se0[3], 1);
        line_k[3] = 1;
        wr(0, 8'h08);
        line_k[3] = 0;
        wr(0, 8'h88);
        wait_enabled(3);
        check("R10", port_en[3], 1);
        rd("R9", 1, 8'h00);
        wr(0, 8'h00);

        // R5 hub suspended blocks detection
        wr(0, 8'h01);
        hub_suspended = 1;
        line_k[0] = 1;
        repeat (5) @(negedge clk);
        check("R5", drv_k[0], 0);
        check("R5", hub_irq, 0);
        rd("R5", 1, 0);
        line_k[0] = 0;
        hub_suspended = 0;
        wr(0, 8'h00);
        repeat (3) @(negedge clk);

        // R11 two ports at once
        wr(0, 8'h05);
        repeat (2) @(negedge clk);
        sb.push_back('{0, C_K, K_MS * MS_P, 1'b0, "R7"});
        sb.push_back('{2, C_K, K_MS * MS_P, 1'b0, "R7"});
        sb.push_back('{0, C_SE0, 2 * BT_P, 1'b1, "R8"});
        sb.push_back('{2, C_SE0, 2 * BT_P, 1'b1, "R8"});
        sb.push_back('{0, C_J, BT_P, 1'b1, "R8"});
        sb.push_back('{2, C_J, BT_P, 1'b1, "R8"});
        sb.push_back('{0, C_IDLE, 1, 1'b1, "R8"});
        sb.push_back('{2, C_IDLE, 1, 1'b1, "R8"});
        line_k = 4'b0101;
        @(negedge clk);
        line_k = '0;
        rd("R4", 1, 8'h05);
        wr(0, 8'h04);
        rd("R6", 1, 8'h04);
        check("R11", hub_irq, 1);
        wr(0, 8'h00);
        rd("R6", 1, 8'h00);
        check("R11", hub_irq, 0);
        wait_enabled(0);
        wait_enabled(2);
        check("R10", port_en, 4'hF);

        check("R8", sb.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule